// File: doc/BRIEF.md
# Sixteen-chip-per-cycle long scrambling code generator

This block produces the two binary long scrambling sequences of a 25-stage Gold-code scheme. It produces sixteen chips of each sequence per clock. One sequence, named c1 here, is the chip-wise XOR of two 25-stage shift registers, x and y. The other, c2, is a fixed XOR of shifted taps of the same two registers. Each register advances sixteen steps in one cycle. The sixteen future feedback bits are computed in parallel and shifted in at the top, while the nine oldest surviving stages move down to the bottom.

A start pulse loads a 24-bit code number into the x register and sets the y register to all ones. The block then presents one word pair at a time on a valid/advance handshake. A word is consumed in a cycle where both `valid_o` and `adv_i` are high. After 2400 consumed words (38400 chips), the last word carries a frame-end flag and the generator goes idle until the next start pulse.

Top module: `long_code_gen`

## Requirements
- R1: After reset, `valid_o` and `frame_end_o` are low and stay low until a start pulse.
- R2: On a cycle with `start_i` high, x stages 0..23 take `code_i[23:0]` (stage k from bit k), x stage 24 is set to 1, and all 25 y stages are set to 1. `valid_o` is high in the next cycle.
- R3: Bit j of `c1_o` is chip n+j, where n is the index of the chip at stage 0. Bit 0 is the earliest chip. Chip value c1(t) = x(t) XOR y(t).
- R4: Chip value c2(t) = x(t+4) XOR x(t+7) XOR x(t+18) XOR y(t+4) XOR y(t+6) XOR y(t+17), with bit j of `c2_o` holding c2(n+j).
- R5: The x sequence obeys x(t+25) = x(t) XOR x(t+3).
- R6: The y sequence obeys y(t+25) = y(t) XOR y(t+1) XOR y(t+2) XOR y(t+3).
- R7: A consumed word moves both registers on by exactly 16 chips. While `valid_o` is high and `adv_i` is low, the outputs hold steady.
- R8: `frame_end_o` is high exactly with the 2400th word of a frame. Once that word is consumed, `valid_o` drops and stays low until the next start pulse.
- R9: A start pulse in the middle of a frame abandons it and begins a fresh 2400-word frame from the new code number.
- R10: A start pulse takes priority over a simultaneous advance; that cycle consumes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load code number and begin a frame |
| code_i | input | 24 | Code number sampled on start |
| adv_i | input | 1 | Consumer takes the current word |
| valid_o | output | 1 | Word pair on c1_o/c2_o is valid |
| c1_o | output | 16 | Sixteen chips of c1, bit 0 earliest |
| c2_o | output | 16 | Sixteen chips of c2, bit 0 earliest |
| frame_end_o | output | 1 | Current word is the last of the frame |

## Verification
The properties assume that `start_i` is a single-cycle pulse, that `code_i` matters only in that cycle, and that `adv_i` may toggle freely, including while idle or together with a start. The stimulus raises start for one cycle at a time and drives every input to a known level from reset onward. It varies `adv_i` between continuous acceptance and random stalls, and it places a restart both mid-frame with the advance asserted and right after a frame ends. Expected words come from a bit-serial model of both registers.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int unsigned STAGES      = 25;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned EXT_W       = STAGES + WORD_W;
  localparam int unsigned CODE_W      = STAGES - 1;
  localparam int unsigned FRAME_WORDS = 2400;

  // feedback taps, bit k set => stage k enters the new bit
  localparam logic [STAGES-1:0] X_FB_MASK = STAGES'(25'h000_0009);
  localparam logic [STAGES-1:0] Y_FB_MASK = STAGES'(25'h000_000F);

  // c2 tap offsets relative to the chip position
  localparam int unsigned X_TAP_A = 4;
  localparam int unsigned X_TAP_B = 7;
  localparam int unsigned X_TAP_C = 18;
  localparam int unsigned Y_TAP_A = 4;
  localparam int unsigned Y_TAP_B = 6;
  localparam int unsigned Y_TAP_C = 17;
endpackage

// File: rtl/lcg_leap.sv
module lcg_leap #(
  parameter int unsigned            STAGES  = 25,
  parameter int unsigned            STEP    = 16,
  parameter logic [STAGES-1:0]      FB_MASK = 25'h9,
  localparam int unsigned           EXT_W   = STAGES + STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAGES-1:0] seed_i,
  input  logic              step_i,
  output logic [EXT_W-1:0]  ext_o
);
  logic [STAGES-1:0] state_q, state_d;
  logic [STEP-1:0]   fb;

  // each future bit reads only current stages: top tap + STEP must fit
  for (genvar k = 0; k < STEP; k++) begin : g_fb
    assign fb[k] = ^(FB_MASK & (state_q >> k));
  end

  assign ext_o = {fb, state_q};

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = seed_i;
    else if (step_i) state_d = {fb, state_q[STAGES-1:STEP]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  a_r2_seed_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_q == $past(seed_i));
  a_r7_low_stages_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_q[STAGES-STEP-1:0] == $past(state_q[STAGES-1:STEP]));
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/lcg_combine.sv
module lcg_combine
  import lcg_pkg::*;
(
  input  logic [EXT_W-1:0]  x_ext_i,
  input  logic [EXT_W-1:0]  y_ext_i,
  output logic [WORD_W-1:0] c1_o,
  output logic [WORD_W-1:0] c2_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_chip
    assign c1_o[i] = x_ext_i[i] ^ y_ext_i[i];
    assign c2_o[i] = x_ext_i[i+X_TAP_A] ^ x_ext_i[i+X_TAP_B] ^ x_ext_i[i+X_TAP_C]
                   ^ y_ext_i[i+Y_TAP_A] ^ y_ext_i[i+Y_TAP_B] ^ y_ext_i[i+Y_TAP_C];
  end
endmodule

// File: rtl/lcg_frame.sv
module lcg_frame #(
  parameter int unsigned  FRAME_WORDS = 2400,
  localparam int unsigned CNT_W       = $clog2(FRAME_WORDS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adv_i,
  output logic valid_o,
  output logic last_o,
  output logic step_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign valid_o = run_q;
  assign last_o  = run_q && (cnt_q == CNT_W'(FRAME_WORDS - 1));
  assign step_o  = run_q && adv_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (step_o) begin
      if (last_o) run_q <= 1'b0;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  a_r2_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && cnt_q == '0);
  a_r8_end_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r8_stop_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last_o) |=> !valid_o);
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> !valid_o);
  a_r10_start_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !step_o);
  a_r7_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_WORDS));
endmodule

// File: rtl/long_code_gen.sv
module long_code_gen
  import lcg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              adv_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] c1_o,
  output logic [WORD_W-1:0] c2_o,
  output logic              frame_end_o
);
  logic             step;
  logic [EXT_W-1:0] x_ext, y_ext;

  lcg_frame #(.FRAME_WORDS(FRAME_WORDS)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv_i),
    .valid_o (valid_o),
    .last_o  (frame_end_o),
    .step_o  (step)
  );

  lcg_leap #(.STAGES(STAGES), .STEP(WORD_W), .FB_MASK(X_FB_MASK)) u_x (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .seed_i ({1'b1, code_i}),
    .step_i (step),
    .ext_o  (x_ext)
  );

  lcg_leap #(.STAGES(STAGES), .STEP(WORD_W), .FB_MASK(Y_FB_MASK)) u_y (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .seed_i ({STAGES{1'b1}}),
    .step_i (step),
    .ext_o  (y_ext)
  );

  lcg_combine u_comb (
    .x_ext_i (x_ext),
    .y_ext_i (y_ext),
    .c1_o    (c1_o),
    .c2_o    (c2_o)
  );

  a_r7_stall_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !adv_i && !start_i) |=> $stable(c1_o) && $stable(c2_o) && valid_o);
  a_r1_end_flag_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !frame_end_o);
endmodule

// File: tb/long_code_gen_tb.sv
module long_code_gen_tb;
  typedef struct packed {
    logic [15:0] c1;
    logic [15:0] c2;
    logic        last;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] code_i = '0;
  logic        adv_i = 1'b0;
  logic        valid_o, frame_end_o;
  logic [15:0] c1_o, c2_o;

  int   n_run = 0, n_fail = 0;
  int   stall_mode = 0;   // 0: hold low, 1: always take, 2: random stalls
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  long_code_gen u_dut (
    .clk_i, .rst_ni, .start_i, .code_i, .adv_i,
    .valid_o, .c1_o, .c2_o, .frame_end_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit-serial reference of both registers (R3..R6)
  task automatic push_frame(input logic [23:0] code, input int words);
    logic [24:0] rx, ry;
    exp_t e;
    rx = {1'b1, code};
    ry = '1;
    q.delete();
    for (int w = 0; w < words; w++) begin
      for (int j = 0; j < 16; j++) begin
        e.c1[j] = rx[0] ^ ry[0];
        e.c2[j] = rx[4] ^ rx[7] ^ rx[18] ^ ry[4] ^ ry[6] ^ ry[17];
        rx = {rx[0] ^ rx[3], rx[24:1]};
        ry = {ry[0] ^ ry[1] ^ ry[2] ^ ry[3], ry[24:1]};
      end
      e.last = (w == words - 1);
      q.push_back(e);
    end
  endtask

  task automatic start_frame(input logic [23:0] code);
    @(posedge clk_i); #1;
    push_frame(code, 2400);
    code_i  = code;
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(posedge clk_i);
    #1;
  endtask

  // advance driver
  initial forever begin
    @(posedge clk_i); #1;
    case (stall_mode)
      0:       adv_i = 1'b0;
      1:       adv_i = 1'b1;
      default: adv_i = ($urandom % 4) != 0;
    endcase
  end

  // monitor: compare pending word every valid cycle, pop on transfer
  always @(negedge clk_i) begin
    if (rst_ni && valid_o && !start_i) begin
      if (q.size() == 0) begin
        check("R8 valid after frame", {63'd0, valid_o}, 64'd0);
      end else begin
        check("R3 c1 word", {48'd0, c1_o}, {48'd0, q[0].c1});
        check("R4 c2 word", {48'd0, c2_o}, {48'd0, q[0].c2});
        check("R8 frame_end", {63'd0, frame_end_o}, {63'd0, q[0].last});
        if (adv_i) void'(q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check("R1 valid after reset", {63'd0, valid_o}, 64'd0);
    check("R1 frame_end after reset", {63'd0, frame_end_o}, 64'd0);
    rst_ni = 1'b1;
    stall_mode = 1;
    repeat (4) @(posedge clk_i);
    #1;
    check("R1 idle without start", {63'd0, valid_o}, 64'd0);

    // R2/R5/R6 full frame, code zero, no stalls
    stall_mode = 0;
    start_frame(24'h000000);
    check("R2 valid after start", {63'd0, valid_o}, 64'd1);
    stall_mode = 1;
    wait_drain();
    repeat (3) begin
      @(negedge clk_i);
      check("R8 idle after frame end", {63'd0, valid_o}, 64'd0);
    end

    // R7 random stalls, nonzero code
    stall_mode = 2;
    start_frame(24'hA5C3_17);
    wait_drain();

    // R9/R10 restart mid-frame with advance high
    stall_mode = 1;
    start_frame(24'h123456);
    repeat (100) @(posedge clk_i);
    start_frame(24'hFEDCBA);   // adv_i stays high through start: R10
    check("R9 valid after restart", {63'd0, valid_o}, 64'd1);
    wait_drain();

    // R2 all-ones code, restart right after frame end
    stall_mode = 2;
    start_frame(24'hFFFFFF);
    wait_drain();
    repeat (2) begin
      @(negedge clk_i);
      check("R8 stopped", {63'd0, valid_o}, 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule